// File: doc/BRIEF.md
# Masked Interrupt Status Controller

This block collects interrupt sources for a serial bus controller and drives one interrupt line. Single-cycle event pulses from the transmit and receive paths, plus one level input that stays high while the receive buffer holds at least one frame, are latched into a status register. A mask register stops an event before it can be latched. An enable register then selects which latched bits may drive the interrupt line. The mask acts before the status register and the enable acts after it, so a masked event leaves no trace, while a latched but disabled bit waits in status and reaches the line as soon as its enable is set.

Software uses a 32-bit register port with a 3-bit word address. It clears status by writing ones to it. It changes enable and mask only through separate set and clear addresses, so it never needs a read-modify-write. The address decoder is a small enumerated selector with the states SEL_STAT, SEL_EN_SET, SEL_EN_CLR, SEL_MASK_SET, SEL_MASK_CLR and SEL_NONE. The selector is combinational and moves to whichever state the current word address names, with SEL_NONE for every unassigned address. Each write strobe and each read path follows from the selector state.

Top module: `irq_status_ctrl`

## Requirements
- R1: An event whose mask bit is 1 in the cycle it arrives is not latched: the status bit stays 0.
- R2: An event whose mask bit is 0 sets its status bit at the next clock edge, and the bit stays set until a write clears it.
- R3: A write to word address 0 (status) clears exactly the status bits written as 1 and leaves the bits written as 0 unchanged.
- R4: If an unmasked event and a status write with a 1 hit the same bit in the same cycle, the bit ends up set.
- R5: A write to address 1 ORs the written ones into enable, and a write to address 2 clears them. A read of address 1 or address 2 returns the current enable value.
- R6: A write to address 3 ORs the written ones into mask, and a write to address 4 clears them. A read of address 3 or address 4 returns the current mask value.
- R7: `irq` is high exactly when (status AND enable) is nonzero. It reflects the register state after each clock edge, so it rises right after the edge that sets an enable for a bit that is already latched.
- R8: While `rx_pending` is high and mask bit 4 is 0, status bit 4 is requested again every cycle, so a clear written during that time does not stick. Once `rx_pending` is low, a clear does stick.
- R9: The status, enable and mask bit positions are: 0 receive done, 1 transmit done, 2 receive overrun, 3 receive full, 4 receive pending, 5 transmit buffer state change. Bits 31..6 read as 0. Addresses 5 to 7 read as 0, and writes to them have no effect.
- R10: While `rst_n` is low, status, enable and mask are 0 and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 3 | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for reg_addr |
| ev_rx_done | input | 1 | Pulse: a frame was received |
| ev_tx_done | input | 1 | Pulse: a frame was transmitted |
| ev_rx_overrun | input | 1 | Pulse: the receive buffer overran |
| ev_rx_full | input | 1 | Pulse: the receive buffer became full |
| rx_pending | input | 1 | Level: the receive buffer holds frames |
| ev_txbuf_chg | input | 1 | Pulse: a transmit buffer changed state |
| irq | output | 1 | Interrupt line |

## Verification
The bench goes after the difference between mask and enable. For each of the six bits it checks the following:
- A masked pulse leaves status at zero. A design that applied the mask at the output would later raise the line when the mask is cleared.
- A latched bit with enable off stays silent, and the line rises at the edge that enables it. A design that gated latching with enable would lose the event.
- Write-one-to-clear touches only the bits written as 1. A design that stored the written value would wipe unrelated bits.

The bench also covers the following cases:
- An event coinciding with its own clear must survive, or a pulse is silently dropped.
- The pending level must re-arm bit 4 after a clear.
- All 4096 status and enable pairs are swept against the expected line value.
- Unassigned addresses must neither alias a register nor disturb one.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int DATA_W  = 32;
    localparam int ADDR_W  = 3;
    localparam int NUM_SRC = 6;

    // Bit positions of the interrupt sources
    localparam int B_RX_DONE  = 0;
    localparam int B_TX_DONE  = 1;
    localparam int B_OVERRUN  = 2;
    localparam int B_RX_FULL  = 3;
    localparam int B_RX_PEND  = 4;
    localparam int B_TXB_CHG  = 5;

    // Word addresses of the register port
    localparam logic [ADDR_W-1:0] A_STAT     = 3'd0;
    localparam logic [ADDR_W-1:0] A_EN_SET   = 3'd1;
    localparam logic [ADDR_W-1:0] A_EN_CLR   = 3'd2;
    localparam logic [ADDR_W-1:0] A_MASK_SET = 3'd3;
    localparam logic [ADDR_W-1:0] A_MASK_CLR = 3'd4;

    typedef enum logic [2:0] {
        SEL_STAT,
        SEL_EN_SET,
        SEL_EN_CLR,
        SEL_MASK_SET,
        SEL_MASK_CLR,
        SEL_NONE
    } reg_sel_e;

endpackage

// File: rtl/irqc_decode.sv
module irqc_decode
    import irqc_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    output reg_sel_e          sel,
    output logic              wr_stat,
    output logic              wr_en_set,
    output logic              wr_en_clr,
    output logic              wr_mask_set,
    output logic              wr_mask_clr
);

    always_comb begin
        unique case (addr)
            A_STAT:     sel = SEL_STAT;
            A_EN_SET:   sel = SEL_EN_SET;
            A_EN_CLR:   sel = SEL_EN_CLR;
            A_MASK_SET: sel = SEL_MASK_SET;
            A_MASK_CLR: sel = SEL_MASK_CLR;
            default:    sel = SEL_NONE;
        endcase
    end

    always_comb begin
        wr_stat     = wr && (sel == SEL_STAT);
        wr_en_set   = wr && (sel == SEL_EN_SET);
        wr_en_clr   = wr && (sel == SEL_EN_CLR);
        wr_mask_set = wr && (sel == SEL_MASK_SET);
        wr_mask_clr = wr && (sel == SEL_MASK_CLR);
    end

endmodule

// File: rtl/irqc_setclr_reg.sv
module irqc_setclr_reg #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         set_en,
    input  logic         clr_en,
    input  logic [W-1:0] bits,
    output logic [W-1:0] q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (set_en) begin
            q <= q | bits;
        end else if (clr_en) begin
            q <= q & ~bits;
        end
    end

endmodule

// File: rtl/irqc_status.sv
module irqc_status #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] req,
    input  logic [W-1:0] mask,
    input  logic         clr_en,
    input  logic [W-1:0] clr_bits,
    output logic [W-1:0] q
);

    for (genvar i = 0; i < W; i++) begin : g_bit
        logic hit;
        assign hit = req[i] & ~mask[i];

        // A fresh event beats a same-cycle clear of the same bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                q[i] <= 1'b0;
            end else if (hit) begin
                q[i] <= 1'b1;
            end else if (clr_en && clr_bits[i]) begin
                q[i] <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl
    import irqc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              ev_rx_done,
    input  logic              ev_tx_done,
    input  logic              ev_rx_overrun,
    input  logic              ev_rx_full,
    input  logic              rx_pending,
    input  logic              ev_txbuf_chg,
    output logic              irq
);

    reg_sel_e           sel;
    logic               wr_stat, wr_en_set, wr_en_clr, wr_mask_set, wr_mask_clr;
    logic [NUM_SRC-1:0] wbits;
    logic [NUM_SRC-1:0] req_raw;
    logic [NUM_SRC-1:0] stat_q;
    logic [NUM_SRC-1:0] en_q;
    logic [NUM_SRC-1:0] mask_q;
    logic               unused_wdata_hi;

    assign wbits           = reg_wdata[NUM_SRC-1:0];
    assign unused_wdata_hi = ^reg_wdata[DATA_W-1:NUM_SRC];

    always_comb begin
        req_raw             = '0;
        req_raw[B_RX_DONE]  = ev_rx_done;
        req_raw[B_TX_DONE]  = ev_tx_done;
        req_raw[B_OVERRUN]  = ev_rx_overrun;
        req_raw[B_RX_FULL]  = ev_rx_full;
        req_raw[B_RX_PEND]  = rx_pending;
        req_raw[B_TXB_CHG]  = ev_txbuf_chg;
    end

    irqc_decode u_dec (
        .addr        (reg_addr),
        .wr          (reg_wr),
        .sel         (sel),
        .wr_stat     (wr_stat),
        .wr_en_set   (wr_en_set),
        .wr_en_clr   (wr_en_clr),
        .wr_mask_set (wr_mask_set),
        .wr_mask_clr (wr_mask_clr)
    );

    irqc_status #(.W(NUM_SRC)) u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (req_raw),
        .mask     (mask_q),
        .clr_en   (wr_stat),
        .clr_bits (wbits),
        .q        (stat_q)
    );

    irqc_setclr_reg #(.W(NUM_SRC)) u_en (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_en (wr_en_set),
        .clr_en (wr_en_clr),
        .bits   (wbits),
        .q      (en_q)
    );

    irqc_setclr_reg #(.W(NUM_SRC)) u_mask (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_en (wr_mask_set),
        .clr_en (wr_mask_clr),
        .bits   (wbits),
        .q      (mask_q)
    );

    always_comb begin
        reg_rdata = '0;
        unique case (sel)
            SEL_STAT:                  reg_rdata[NUM_SRC-1:0] = stat_q;
            SEL_EN_SET, SEL_EN_CLR:    reg_rdata[NUM_SRC-1:0] = en_q;
            SEL_MASK_SET, SEL_MASK_CLR: reg_rdata[NUM_SRC-1:0] = mask_q;
            default:                   reg_rdata = '0;
        endcase
    end

    assign irq = |(stat_q & en_q);

endmodule

// File: rtl/irq_status_ctrl_chk.sv
module irq_status_ctrl_chk #(
    parameter int N = 6
) (
    input logic         clk,
    input logic         rst_n,
    input logic         reg_wr,
    input logic [2:0]   reg_addr,
    input logic [N-1:0] wbits,
    input logic [N-1:0] req,
    input logic [N-1:0] stat,
    input logic [N-1:0] en,
    input logic [N-1:0] mask,
    input logic         irq
);

    a_r1_mask_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((stat & ~$past(stat) & $past(mask)) == '0));

    // R2 and R4: every unmasked request is latched at the next edge
    a_r2_latch: assert property (@(posedge clk) disable iff (!rst_n)
        (|(req & ~mask)) |=> ((stat & $past(req & ~mask)) == $past(req & ~mask)));

    a_r3_w1c: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 3'd0) |=> ((stat & $past(wbits & ~req)) == '0));

    a_r5_en_set: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 3'd1) |=> ((en & $past(wbits)) == $past(wbits)));

    a_r6_mask_clr: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 3'd4) |=> ((mask & $past(wbits)) == '0));

    a_r7_irq_on_enable: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 3'd1 && (|(wbits & stat))) |=> irq);

    a_r10_reset: assert property (@(posedge clk)
        !rst_n |-> (stat == '0 && en == '0 && mask == '0 && !irq));

endmodule

bind irq_status_ctrl irq_status_ctrl_chk #(.N(irqc_pkg::NUM_SRC)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_wr   (reg_wr),
    .reg_addr (reg_addr),
    .wbits    (wbits),
    .req      (req_raw),
    .stat     (stat_q),
    .en       (en_q),
    .mask     (mask_q),
    .irq      (irq)
);

// File: tb/irq_status_ctrl_tb_top.sv
`timescale 1ns/1ps
module irq_status_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [5:0]  ev = '0;
    logic        pend_lvl = 1'b0;
    logic        irq;
    int          compared = 0;
    int          mismatched = 0;
    bit          finished = 1'b0;

    always #10 clk = ~clk;

    irq_status_ctrl dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .reg_wr        (reg_wr),
        .reg_addr      (reg_addr),
        .reg_wdata     (reg_wdata),
        .reg_rdata     (reg_rdata),
        .ev_rx_done    (ev[0]),
        .ev_tx_done    (ev[1]),
        .ev_rx_overrun (ev[2]),
        .ev_rx_full    (ev[3]),
        .rx_pending    (ev[4] | pend_lvl),
        .ev_txbuf_chg  (ev[5]),
        .irq           (irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic pulse(input logic [5:0] v);
        @(negedge clk);
        ev = v;
        @(negedge clk);
        ev = '0;
    endtask

    task automatic ev_and_wr(input logic [5:0] v, input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        ev = v; reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        ev = '0; reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            mismatched++;
            compared++;
            $display("FAIL watchdog actual=%h expected=%h", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        // R10: reset values
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), d);
            chk("R10 reset read", d, 32'h0);
        end
        chk("R10 irq in reset", {31'b0, irq}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;

        // Per-bit sweep: R1, R2, R3, R5, R6, R7, R9
        for (int b = 0; b < 6; b++) begin
            logic [31:0] one;
            one = 32'h1 << b;
            wr(3'd3, one);
            rd(3'd3, d); chk("R6 mask via set addr", d, one);
            rd(3'd4, d); chk("R6 mask via clr addr", d, one);
            pulse(6'(one));
            rd(3'd0, d); chk("R1 masked event not latched", d, 32'h0);
            wr(3'd4, one);
            rd(3'd3, d); chk("R6 mask cleared", d, 32'h0);
            pulse(6'(one));
            rd(3'd0, d); chk("R2 R9 event latched at its bit", d, one);
            chk("R7 irq low with enable off", {31'b0, irq}, 32'h0);
            wr(3'd1, one);
            chk("R7 irq rises on enable", {31'b0, irq}, 32'h1);
            rd(3'd1, d); chk("R5 enable via set addr", d, one);
            rd(3'd2, d); chk("R5 enable via clr addr", d, one);
            wr(3'd0, ~one);
            rd(3'd0, d); chk("R3 zeros leave status", d, one);
            wr(3'd0, one);
            rd(3'd0, d); chk("R3 one clears status", d, 32'h0);
            chk("R7 irq low after clear", {31'b0, irq}, 32'h0);
            wr(3'd2, one);
            rd(3'd1, d); chk("R5 enable cleared", d, 32'h0);
        end

        // R4: event beats a same-cycle clear
        pulse(6'h01);
        pulse(6'h02);
        ev_and_wr(6'h01, 3'd0, 32'h3);
        rd(3'd0, d); chk("R4 event wins over clear", d, 32'h1);
        wr(3'd0, 32'h3F);

        // R8: pending level re-arms bit 4
        @(negedge clk); pend_lvl = 1'b1;
        @(negedge clk);
        rd(3'd0, d); chk("R8 pending latched", d, 32'h10);
        wr(3'd0, 32'h10);
        rd(3'd0, d); chk("R8 clear does not stick while pending", d, 32'h10);
        wr(3'd3, 32'h10);
        wr(3'd0, 32'h10);
        @(negedge clk);
        rd(3'd0, d); chk("R8 masked pending stays clear", d, 32'h0);
        wr(3'd4, 32'h10);
        @(negedge clk);
        rd(3'd0, d); chk("R8 unmasked pending re-arms", d, 32'h10);
        pend_lvl = 1'b0;
        @(negedge clk);
        wr(3'd0, 32'h10);
        rd(3'd0, d); chk("R8 clear sticks when idle", d, 32'h0);

        // R9: upper bits and unassigned addresses
        wr(3'd1, 32'hFFFF_FFFF);
        rd(3'd1, d); chk("R9 upper enable bits read zero", d, 32'h3F);
        pulse(6'h21);
        for (int a = 5; a < 8; a++) begin
            wr(3'(a), 32'hFFFF_FFFF);
            rd(3'(a), d); chk("R9 unassigned address reads zero", d, 32'h0);
        end
        rd(3'd0, d); chk("R9 status untouched", d, 32'h21);
        rd(3'd1, d); chk("R9 enable untouched", d, 32'h3F);
        rd(3'd3, d); chk("R9 mask untouched", d, 32'h0);
        wr(3'd2, 32'h3F);
        wr(3'd0, 32'h3F);

        // R7: full sweep of status and enable patterns
        for (int s = 0; s < 64; s++) begin
            wr(3'd0, 32'h3F);
            if (s != 0) pulse(6'(s));
            for (int e = 0; e < 64; e++) begin
                wr(3'd2, 32'h3F);
                wr(3'd1, 32'(e));
                chk("R7 irq sweep", {31'b0, irq}, {31'b0, ((s & e) != 0)});
            end
        end

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule